// File: doc/BRIEF.md
# Board Reset Sequencer and JTAG Router

This block sits in a small companion logic device on a module board. It drives the active-low configuration reset of the main FPGA. After board power-up it holds that reset for a fixed number of clock cycles. From then on it asserts the reset whenever any of three active-low board lines is low: the external push-button reset, the power-monitor good line and the carrier enable line. Each of those lines passes through a two-flop synchroniser before it is combined. The same reset level is reported to the carrier on an open-drain status pin, which is pulled low while the reset is asserted and released otherwise. The regulator enable pin is never driven and relies on its external pull-up. Both pins are modelled as a value plus an output-enable.

The block also routes the external JTAG pins. A select input decides whether the external TCK, TMS and TDI reach the FPGA, with the FPGA's TDO returned, or reach the local device instead. Whichever side is not selected sees a safe idle level: TCK low, TMS high, TDI high. The routing is purely combinational, because the JTAG clock is unrelated to the board clock.

The reset controller is a three-state machine:
- ST_POWERUP is entered on board reset and counts the power-on delay.
- ST_RUN releases the reset.
- ST_HOLD asserts the reset while a source is low.

Transitions:
- ST_POWERUP→ST_RUN when the count expires and all sources are high.
- ST_POWERUP→ST_HOLD when the count expires and a source is low.
- ST_RUN→ST_HOLD when any synchronised source is low.
- ST_HOLD→ST_RUN when all synchronised sources are high.

Top module: `board_reset_router`

## Requirements
- R1: While `rst_n` is low, `cfg_rst_n_o` is 0 and `stat_oe_o` is 1.
- R2: After `rst_n` rises, `cfg_rst_n_o` stays 0 for POR_CYCLES-1 rising edges. It becomes 1 after the POR_CYCLES-th rising edge if all three sources have been high.
- R3: After the power-on delay, a change on any of `ext_rst_n_i`, `pwr_ok_i` or `carrier_en_i` appears on `cfg_rst_n_o` after the third rising edge. `cfg_rst_n_o` equals the AND of the three lines. It is unchanged after two edges.
- R4: If a source is low when the power-on delay expires, `cfg_rst_n_o` stays 0. It rises on the third edge after all sources are high.
- R5: `stat_oe_o` is 1 exactly when `cfg_rst_n_o` is 0, and `stat_o` is always 0. The line is either pulled low or released.
- R6: `regen_oe_o` is always 0, and the regulator enable is never driven.
- R7: With `jtag_sel_i`=0, the external pins pass through to the FPGA side:
  - `fpga_tck_o`, `fpga_tms_o` and `fpga_tdi_o` follow `ext_tck_i`, `ext_tms_i` and `ext_tdi_i`.
  - `ext_tdo_o` follows `fpga_tdo_i`.
  - The local side idles with TCK=0, TMS=1 and TDI=1.
- R8: With `jtag_sel_i`=1, the external pins go to the local side:
  - The `loc_*` outputs follow the external pins.
  - `ext_tdo_o` follows `loc_tdo_i`.
  - The FPGA side idles with TCK=0, TMS=1 and TDI=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Board power-on reset, active low |
| ext_rst_n_i | input | 1 | External reset line, low asserts |
| pwr_ok_i | input | 1 | Power-good line, low asserts |
| carrier_en_i | input | 1 | Carrier enable line, low asserts |
| cfg_rst_n_o | output | 1 | FPGA configuration reset, active low |
| stat_o | output | 1 | Status pin value (always 0) |
| stat_oe_o | output | 1 | Status pin output enable |
| regen_o | output | 1 | Regulator enable value |
| regen_oe_o | output | 1 | Regulator enable output enable (always 0) |
| jtag_sel_i | input | 1 | 0: JTAG to FPGA, 1: JTAG to local device |
| ext_tck_i | input | 1 | External TCK |
| ext_tms_i | input | 1 | External TMS |
| ext_tdi_i | input | 1 | External TDI |
| ext_tdo_o | output | 1 | External TDO |
| fpga_tck_o | output | 1 | FPGA TCK |
| fpga_tms_o | output | 1 | FPGA TMS |
| fpga_tdi_o | output | 1 | FPGA TDI |
| fpga_tdo_i | input | 1 | FPGA TDO |
| loc_tck_o | output | 1 | Local TCK |
| loc_tms_o | output | 1 | Local TMS |
| loc_tdi_o | output | 1 | Local TDI |
| loc_tdo_i | input | 1 | Local TDO |

## Verification
Expiry of the power-on count and a low reset source can fall on the same clock edge. The bench provokes this by holding the external reset low through the whole delay, then checking that the state machine goes to hold rather than run, and that the reset rises exactly three edges after the source is released. JTAG select changes and pin toggles are also applied while a reset source is changing. Both the routing and the reset level are judged against bench functions in the same sample.

// File: rtl/brr_pkg.sv
package brr_pkg;
    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        ST_POWERUP = 2'd0,
        ST_RUN     = 2'd1,
        ST_HOLD    = 2'd2
    } rst_state_e;

    localparam logic IDLE_TCK = 1'b0;
    localparam logic IDLE_TMS = 1'b1;
    localparam logic IDLE_TDI = 1'b1;
endpackage

// File: rtl/brr_sync.sv
module brr_sync #(
    parameter int   WIDTH   = 3,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q[s] <= {WIDTH{RST_VAL}};
                end else if (s == 0) begin
                    pipe_q[s] <= d_i;
                end else begin
                    pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/brr_reset_fsm.sv
module brr_reset_fsm
    import brr_pkg::*;
#(
    parameter int POR_CYCLES = 65536
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_ok_i,
    output logic               cfg_rst_n_o,
    output logic               stat_oe_o
);
    localparam int CNT_W = (POR_CYCLES > 2) ? $clog2(POR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POR_CYCLES - 1);

    rst_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             all_ok;

    assign all_ok = &src_ok_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_POWERUP && cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWERUP: if (cnt_q == CNT_LAST) state_d = all_ok ? ST_RUN : ST_HOLD;
            ST_RUN:     if (!all_ok)           state_d = ST_HOLD;
            ST_HOLD:    if (all_ok)            state_d = ST_RUN;
            default:                           state_d = ST_POWERUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_POWERUP;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  begin cfg_rst_n_o = 1'b1; stat_oe_o = 1'b0; end
            default: begin cfg_rst_n_o = 1'b0; stat_oe_o = 1'b1; end
        endcase
    end

    assert_por_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POWERUP && cnt_q != CNT_LAST) |=> (state_q == ST_POWERUP && !cfg_rst_n_o));

    assert_por_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POWERUP && cnt_q == CNT_LAST && !all_ok) |=> (state_q == ST_HOLD));

    assert_src_assert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_POWERUP && !all_ok) |=> !cfg_rst_n_o);

    assert_src_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_POWERUP && all_ok) |=> cfg_rst_n_o);
endmodule

// File: rtl/brr_jtag_route.sv
module brr_jtag_route
    import brr_pkg::*;
(
    input  logic sel_local_i,
    input  logic ext_tck_i,
    input  logic ext_tms_i,
    input  logic ext_tdi_i,
    output logic ext_tdo_o,
    output logic fpga_tck_o,
    output logic fpga_tms_o,
    output logic fpga_tdi_o,
    input  logic fpga_tdo_i,
    output logic loc_tck_o,
    output logic loc_tms_o,
    output logic loc_tdi_o,
    input  logic loc_tdo_i
);
    always_comb begin
        if (sel_local_i) begin
            loc_tck_o  = ext_tck_i;
            loc_tms_o  = ext_tms_i;
            loc_tdi_o  = ext_tdi_i;
            ext_tdo_o  = loc_tdo_i;
            fpga_tck_o = IDLE_TCK;
            fpga_tms_o = IDLE_TMS;
            fpga_tdi_o = IDLE_TDI;
        end else begin
            fpga_tck_o = ext_tck_i;
            fpga_tms_o = ext_tms_i;
            fpga_tdi_o = ext_tdi_i;
            ext_tdo_o  = fpga_tdo_i;
            loc_tck_o  = IDLE_TCK;
            loc_tms_o  = IDLE_TMS;
            loc_tdi_o  = IDLE_TDI;
        end
    end
endmodule

// File: rtl/board_reset_router.sv
module board_reset_router
    import brr_pkg::*;
#(
    parameter int POR_CYCLES  = 65536,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_rst_n_i,
    input  logic pwr_ok_i,
    input  logic carrier_en_i,
    output logic cfg_rst_n_o,
    output logic stat_o,
    output logic stat_oe_o,
    output logic regen_o,
    output logic regen_oe_o,
    input  logic jtag_sel_i,
    input  logic ext_tck_i,
    input  logic ext_tms_i,
    input  logic ext_tdi_i,
    output logic ext_tdo_o,
    output logic fpga_tck_o,
    output logic fpga_tms_o,
    output logic fpga_tdi_o,
    input  logic fpga_tdo_i,
    output logic loc_tck_o,
    output logic loc_tms_o,
    output logic loc_tdi_o,
    input  logic loc_tdo_i
);
    logic [NUM_SRC-1:0] src_raw;
    logic [NUM_SRC-1:0] src_sync;

    assign src_raw = {carrier_en_i, pwr_ok_i, ext_rst_n_i};

    brr_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b0)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (src_raw),
        .q_o  (src_sync)
    );

    brr_reset_fsm #(
        .POR_CYCLES(POR_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_ok_i   (src_sync),
        .cfg_rst_n_o(cfg_rst_n_o),
        .stat_oe_o  (stat_oe_o)
    );

    assign stat_o     = 1'b0;
    assign regen_o    = 1'b0;
    assign regen_oe_o = 1'b0;

    brr_jtag_route u_jtag (
        .sel_local_i(jtag_sel_i),
        .ext_tck_i  (ext_tck_i),
        .ext_tms_i  (ext_tms_i),
        .ext_tdi_i  (ext_tdi_i),
        .ext_tdo_o  (ext_tdo_o),
        .fpga_tck_o (fpga_tck_o),
        .fpga_tms_o (fpga_tms_o),
        .fpga_tdi_o (fpga_tdi_o),
        .fpga_tdo_i (fpga_tdo_i),
        .loc_tck_o  (loc_tck_o),
        .loc_tms_o  (loc_tms_o),
        .loc_tdi_o  (loc_tdi_o),
        .loc_tdo_i  (loc_tdo_i)
    );

    assert_stat_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_oe_o == !cfg_rst_n_o) && !stat_o);

    assert_fpga_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        jtag_sel_i |-> (fpga_tck_o == IDLE_TCK && fpga_tms_o == IDLE_TMS));

    assert_fpga_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !jtag_sel_i |-> (fpga_tck_o == ext_tck_i && ext_tdo_o == fpga_tdo_i));
endmodule

// File: tb/board_reset_router_bench.sv
module board_reset_router_bench;
    localparam int POR = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst_n_i = 1'b1, pwr_ok_i = 1'b1, carrier_en_i = 1'b1;
    logic jtag_sel_i = 1'b0, ext_tck_i = 1'b0, ext_tms_i = 1'b0, ext_tdi_i = 1'b0;
    logic fpga_tdo_i = 1'b0, loc_tdo_i = 1'b0;
    logic cfg_rst_n_o, stat_o, stat_oe_o, regen_o, regen_oe_o;
    logic ext_tdo_o, fpga_tck_o, fpga_tms_o, fpga_tdi_o, loc_tck_o, loc_tms_o, loc_tdi_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    board_reset_router #(.POR_CYCLES(POR)) u_board_reset_router (
        .clk(clk), .rst_n(rst_n),
        .ext_rst_n_i(ext_rst_n_i), .pwr_ok_i(pwr_ok_i), .carrier_en_i(carrier_en_i),
        .cfg_rst_n_o(cfg_rst_n_o), .stat_o(stat_o), .stat_oe_o(stat_oe_o),
        .regen_o(regen_o), .regen_oe_o(regen_oe_o),
        .jtag_sel_i(jtag_sel_i), .ext_tck_i(ext_tck_i), .ext_tms_i(ext_tms_i),
        .ext_tdi_i(ext_tdi_i), .ext_tdo_o(ext_tdo_o),
        .fpga_tck_o(fpga_tck_o), .fpga_tms_o(fpga_tms_o), .fpga_tdi_o(fpga_tdi_o),
        .fpga_tdo_i(fpga_tdo_i),
        .loc_tck_o(loc_tck_o), .loc_tms_o(loc_tms_o), .loc_tdi_o(loc_tdi_o),
        .loc_tdo_i(loc_tdo_i)
    );

    function automatic logic exp_cfg(input logic a, input logic b, input logic c);
        return a & b & c;
    endfunction

    // {ext_tdo, fpga_tck, fpga_tms, fpga_tdi, loc_tck, loc_tms, loc_tdi}
    function automatic logic [6:0] exp_jtag(input logic sel, input logic tck, input logic tms,
                                            input logic tdi, input logic ftdo, input logic ltdo);
        if (sel) return {ltdo, 1'b0, 1'b1, 1'b1, tck, tms, tdi};
        else     return {ftdo, tck, tms, tdi, 1'b0, 1'b1, 1'b1};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_cfg(input string req, input logic exp);
        check(req, {31'd0, cfg_rst_n_o}, {31'd0, exp});
        check("R5", {30'd0, stat_oe_o, stat_o}, {30'd0, ~exp, 1'b0});
        check("R6", {31'd0, regen_oe_o}, 32'd0);
    endtask

    task automatic check_jtag();
        logic [6:0] e;
        e = exp_jtag(jtag_sel_i, ext_tck_i, ext_tms_i, ext_tdi_i, fpga_tdo_i, loc_tdo_i);
        check(jtag_sel_i ? "R8" : "R7",
              {25'd0, ext_tdo_o, fpga_tck_o, fpga_tms_o, fpga_tdi_o, loc_tck_o, loc_tms_o, loc_tdi_o},
              {25'd0, e});
    endtask

    task automatic set_src(input logic [2:0] v);
        {carrier_en_i, pwr_ok_i, ext_rst_n_i} = v;
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0007));
        step(3);
        check_cfg("R1", 1'b0);

        // R2: power-on delay
        rst_n = 1'b1;
        step(POR - 1);
        check_cfg("R2", 1'b0);
        step(1);
        check_cfg("R2", 1'b1);

        // R3: each source alone, exact latency
        for (int i = 0; i < 3; i++) begin
            set_src(3'b111 & ~(3'b1 << i));
            step(2);
            check_cfg("R3", 1'b1);
            step(1);
            check_cfg("R3", 1'b0);
            set_src(3'b111);
            step(2);
            check_cfg("R3", 1'b0);
            step(1);
            check_cfg("R3", 1'b1);
        end

        // R4: source low across power-on expiry
        rst_n = 1'b0;
        set_src(3'b110);
        step(1);
        check_cfg("R1", 1'b0);
        rst_n = 1'b1;
        step(POR + 5);
        check_cfg("R4", 1'b0);
        set_src(3'b111);
        jtag_sel_i = 1'b1;
        ext_tck_i = 1'b1;
        #1 check_jtag();
        step(2);
        check_cfg("R4", 1'b0);
        step(1);
        check_cfg("R4", 1'b1);

        // directed JTAG corners
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 32; p++) begin
                jtag_sel_i = s[0];
                {ext_tck_i, ext_tms_i, ext_tdi_i, fpga_tdo_i, loc_tdo_i} = p[4:0];
                #1 check_jtag();
            end
        end

        // random mixed stimulus
        for (int k = 0; k < 300; k++) begin
            logic [2:0] v;
            v = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 1) v = 3'b111;
            set_src(v);
            jtag_sel_i = 1'($urandom);
            {ext_tck_i, ext_tms_i, ext_tdi_i, fpga_tdo_i, loc_tdo_i} = 5'($urandom);
            #1 check_jtag();
            step(3);
            check_cfg("R3", exp_cfg(v[0], v[1], v[2]));
            check_jtag();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule